// File: doc/BRIEF.md
# Per-CPU Masked Interrupt Aggregator

This block is a first-level interrupt controller that gathers a bank of level-sensitive interrupt source lines and produces one interrupt request per CPU. The source count is a whole number of 32-bit groups. Every CPU owns a private set of read/write enable words. All CPUs share the same read-only status view of the sources. A CPU's request line goes high whenever a source that is currently pending is also enabled in that CPU's enable set.

Software steers a source to a particular CPU only by setting the source's bit in that CPU's enables. It finds which sources need service by reading a status word and ANDing it with the matching enable word.

Access goes through a simple single-cycle register bus. Each CPU's register bank holds its enable words first, then its status words. The CPU banks are packed back to back. Within a bank, word 0 carries the highest-numbered group of sources.

Top module: `percpu_irq_aggregator`

## Requirements
- R1: After reset every enable bit is 0, every `irq_o` bit is 0 and `rd_data_o` is 0.
- R2: A write to an enable word replaces all 32 of its bits at once, and a later read of that address returns the written value.
- R3: With W words per CPU, the bank for CPU c starts at byte address c·8·W. Enable word k is at bank offset 4·k and status word k is at bank offset 4·(W+k), for k = 0..W-1. Address bits [1:0] are ignored.
- R4: Word index k covers sources (W-1-k)·32 up to (W-1-k)·32+31, with source (W-1-k)·32+j in bit j. The last word therefore holds sources 0–31.
- R5: A status word reads the current synchronized level of its 32 sources, and a write to a status address changes nothing.
- R6: `irq_o[c]` is the OR over all words of (status AND CPU c's enable). A source change reaches `irq_o` three clock edges after it is sampled: two synchronizer stages, then one output register.
- R7: The enable sets of different CPUs are independent. A write to one CPU's bank leaves the other CPU's enables and request line unaffected.
- R8: Reads of word addresses at or above NUM_CPUS·2·W return 0, and writes there have no effect.
- R9: `rd_data_o` is registered. It carries the addressed word on the clock edge where `rd_en_i` is sampled high, and it is 0 after any edge where `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_WORDS*32 | Level-sensitive interrupt sources, bit n is source n |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | NUM_CPUS | Per-CPU interrupt request |

## Verification
The bench builds the block with four words per CPU (128 sources), two CPUs and an 8-bit address. This places both banks, their status words and an unmapped region above 0x40 all within reach of the address bus. The four-word setting lets the bench check that word 0 maps to sources 96–127, word 2 to sources 32–63 and the last word to sources 0–31. It also checks that a source routed through one CPU's enables drives only that CPU's request line.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int GRP_BITS  = 32;
    localparam int IDX_MAX_W = 4;

    typedef enum logic {
        KIND_ENABLE = 1'b0,
        KIND_STATUS = 1'b1
    } reg_kind_e;

    typedef struct packed {
        logic                 hit;
        reg_kind_e            kind;
        logic [IDX_MAX_W-1:0] cpu;
        logic [IDX_MAX_W-1:0] word;
    } reg_sel_t;

    // Lowest source number held by a given word index (highest group in word 0).
    function automatic int group_base(input int word, input int nwords);
        return (nwords - 1 - word) * GRP_BITS;
    endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int WIDTH  = 128,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);
    localparam int BANK_WORDS = 2 * NUM_WORDS;
    localparam int MAP_WORDS  = NUM_CPUS * BANK_WORDS;
    localparam int IDX_W      = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    int               offs;

    assign idx = addr_i[ADDR_W-1:2];

    always_comb begin
        offs       = int'(idx) % BANK_WORDS;
        sel_o.hit  = (int'(idx) < MAP_WORDS);
        sel_o.cpu  = IDX_MAX_W'(int'(idx) / BANK_WORDS);
        sel_o.kind = (offs >= NUM_WORDS) ? KIND_STATUS : KIND_ENABLE;
        sel_o.word = IDX_MAX_W'(offs % NUM_WORDS);
    end
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_WORDS-1:0]               wr_sel_i,
    input  logic [GRP_BITS-1:0]                wr_data_i,
    input  logic [NUM_WORDS*GRP_BITS-1:0]      status_i,
    output logic [NUM_WORDS-1:0][GRP_BITS-1:0] en_o,
    output logic                               irq_o
);
    logic [NUM_WORDS-1:0] word_hit;

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_word
            localparam int BASE = group_base(w, NUM_WORDS);

            always_ff @(posedge clk) begin
                if (rst)              en_o[w] <= '0;
                else if (wr_sel_i[w]) en_o[w] <= wr_data_i;
            end

            assign word_hit[w] = |(status_i[BASE +: GRP_BITS] & en_o[w]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |word_hit;
    end
endmodule

// File: rtl/percpu_irq_aggregator.sv
module percpu_irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int NUM_CPUS    = 2,
    parameter int NUM_WORDS   = 4,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_WORDS*GRP_BITS-1:0] src_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          wr_en_i,
    input  logic [GRP_BITS-1:0]           wr_data_i,
    input  logic                          rd_en_i,
    output logic [GRP_BITS-1:0]           rd_data_o,
    output logic [NUM_CPUS-1:0]           irq_o
);
    localparam int SRC_W = NUM_WORDS * GRP_BITS;

    logic [SRC_W-1:0]                                status;
    reg_sel_t                                        sel;
    logic [NUM_CPUS-1:0][NUM_WORDS-1:0][GRP_BITS-1:0] en_all;
    logic [NUM_CPUS-1:0][NUM_WORDS-1:0]              wr_sel;
    logic [GRP_BITS-1:0]                             rd_word;

    irqagg_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (src_i),
        .q_o (status)
    );

    irqagg_decode #(
        .NUM_CPUS (NUM_CPUS),
        .NUM_WORDS(NUM_WORDS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .addr_i(addr_i),
        .sel_o (sel)
    );

    // Only enable words of a mapped bank accept writes.
    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                wr_sel[c][w] = wr_en_i && sel.hit && (sel.kind == KIND_ENABLE)
                               && (sel.cpu == IDX_MAX_W'(c))
                               && (sel.word == IDX_MAX_W'(w));
            end
        end
    end

    genvar c;
    generate
        for (c = 0; c < NUM_CPUS; c++) begin : g_cpu
            irqagg_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
                .clk      (clk),
                .rst      (rst),
                .wr_sel_i (wr_sel[c]),
                .wr_data_i(wr_data_i),
                .status_i (status),
                .en_o     (en_all[c]),
                .irq_o    (irq_o[c])
            );
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (sel.hit && sel.word == IDX_MAX_W'(w)) begin
                if (sel.kind == KIND_STATUS) begin
                    rd_word = status[group_base(w, NUM_WORDS) +: GRP_BITS];
                end else begin
                    for (int k = 0; k < NUM_CPUS; k++) begin
                        if (sel.cpu == IDX_MAX_W'(k)) rd_word = en_all[k][w];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_word;
        else              rd_data_o <= '0;
    end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
    parameter int NUM_CPUS  = 2,
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_WORDS*32-1:0]   src_i,
    input logic [ADDR_W-1:0]         addr_i,
    input logic                      rd_en_i,
    input logic [31:0]               rd_data_o,
    input logic [NUM_CPUS-1:0]       irq_o
);
    localparam int MAP_WORDS = NUM_CPUS * 2 * NUM_WORDS;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_o == '0 && rd_data_o == '0));

    p_idle_bus_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en_i) |-> rd_data_o == '0);

    p_unmapped_read_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en_i) && (int'($past(addr_i) >> 2) >= MAP_WORDS)) |-> rd_data_o == '0);

    p_no_source_no_irq_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(src_i, 3) == '0) |-> irq_o == '0);

    p_rise_needs_source_r6: assert property (@(posedge clk) disable iff (rst)
        ((irq_o & ~$past(irq_o)) != '0) |-> ($past(src_i, 3) != '0));
endmodule

bind percpu_irq_aggregator irqagg_checker #(
    .NUM_CPUS (NUM_CPUS),
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .src_i    (src_i),
    .addr_i   (addr_i),
    .rd_en_i  (rd_en_i),
    .rd_data_o(rd_data_o),
    .irq_o    (irq_o)
);

// File: tb/percpu_irq_aggregator_test.sv
module percpu_irq_aggregator_test;
    localparam int NW    = 4;
    localparam int NC    = 2;
    localparam int AW    = 8;
    localparam int SRC_W = NW * 32;
    localparam int NVEC  = 10;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [AW-1:0]    wa;
        logic [31:0]      wd;
        logic [AW-1:0]    ra;
        logic [31:0]      exp_rd;
        logic [NC-1:0]    exp_irq;
    } vec_t;

    localparam logic [SRC_W-1:0] ONE = SRC_W'(1);

    // Enables persist from one vector to the next.
    localparam vec_t VECS [NVEC] = '{
        '{'0,                    8'h00, 32'hA5A5_0001, 8'h00, 32'hA5A5_0001, 2'b00}, // R2 write/readback
        '{ONE << 96,             8'hFC, 32'hFFFF_FFFF, 8'h10, 32'h0000_0001, 2'b01}, // R4 R8 word0 = 96..127
        '{ONE,                   8'h2C, 32'h0000_0001, 8'h1C, 32'h0000_0001, 2'b10}, // R3 R7 cpu1 last word
        '{ONE | (ONE << 97),     8'hFE, 32'h0,         8'h30, 32'h0000_0002, 2'b10}, // R3 cpu1 status bank
        '{ONE << 96,             8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_0001, 2'b01}, // R5 status write ignored
        '{ONE << 96,             8'h00, 32'h0,         8'h00, 32'h0,         2'b00}, // R2 full replace
        '{ONE | (ONE << 96),     8'h24, 32'h8000_0000, 8'h2C, 32'h0000_0001, 2'b10}, // R7 cpu1 untouched
        '{ONE << 95,             8'h40, 32'h0000_FFFF, 8'h24, 32'h8000_0000, 2'b10}, // R4 R8 source 95
        '{'0,                    8'h08, 32'hFFFF_FFFF, 8'h40, 32'h0,         2'b00}, // R8 unmapped read
        '{ONE << 63,             8'hFC, 32'h0000_0001, 8'h18, 32'h8000_0000, 2'b01}  // R4 R6 word2 = 32..63
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [SRC_W-1:0] src_i = '0;
    logic [AW-1:0]    addr_i = '0;
    logic             wr_en_i = 1'b0;
    logic [31:0]      wr_data_i = '0;
    logic             rd_en_i = 1'b0;
    logic [31:0]      rd_data_o;
    logic [NC-1:0]    irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    percpu_irq_aggregator #(
        .NUM_CPUS (NC),
        .NUM_WORDS(NW),
        .ADDR_W   (AW)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src_i),
        .addr_i   (addr_i),
        .wr_en_i  (wr_en_i),
        .wr_data_i(wr_data_i),
        .rd_en_i  (rd_en_i),
        .rd_data_o(rd_data_o),
        .irq_o    (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        addr_i    = a;
        wr_data_i = d;
        wr_en_i   = 1'b1;
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i  = a;
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        d       = rd_data_o;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 irq after reset", 32'(irq_o), 32'h0);
        check("R1 rd_data after reset", rd_data_o, 32'h0);
        bus_read(8'h00, rd);
        check("R1 cpu0 enable word0", rd, 32'h0);
        bus_read(8'h2C, rd);
        check("R1 cpu1 enable word3", rd, 32'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            src_i = VECS[i].src;
            bus_write(VECS[i].wa, VECS[i].wd);
            repeat (3) @(negedge clk);
            check($sformatf("R6 irq vector %0d", i), 32'(irq_o), 32'(VECS[i].exp_irq));
            bus_read(VECS[i].ra, rd);
            check($sformatf("R2/R3/R4/R5/R7/R8 read vector %0d", i), rd, VECS[i].exp_rd);
        end

        // R9: no read strobe -> zero read data
        @(negedge clk);
        check("R9 idle rd_data", rd_data_o, 32'h0);

        // R1: reset clears enables again
        src_i = '0;
        rst   = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        bus_read(8'h08, rd);
        check("R1 enable cleared by reset", rd, 32'h0);

        // R6: latency of three edges from source to irq (source 2, cpu0 last word)
        bus_write(8'h0C, 32'h0000_0004);
        @(negedge clk);
        src_i = ONE << 2;
        @(negedge clk);
        check("R6 one edge", 32'(irq_o), 32'h0);
        @(negedge clk);
        check("R6 two edges", 32'(irq_o), 32'h0);
        @(negedge clk);
        check("R6 three edges", 32'(irq_o), 32'h1);
        src_i = '0;
        repeat (3) @(negedge clk);
        check("R6 deassert follows source", 32'(irq_o), 32'h0);

        finish_run();
    end
endmodule